// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches 24 input lines, grouped as three 8-bit ports, for edge events. Each line has two settings of its own: a polarity bit that picks rising or falling edges, and an enable bit. An enabled edge of the chosen polarity sets a sticky pending bit for that line. The bit stays set until the host clears it, so a pulse only one clock wide is still recorded.

The host reads the pending bits through an identification register per port. That register shows which lines fired. Writing ones to it clears those bits. A single level output, `irq`, is high while any pending bit is set. Because it is a plain level, the outputs of two instances can be combined with an OR gate into one request.

Inputs are asynchronous. They pass through a two-stage synchronizer before any edge is detected.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, all polarity, enable and identification registers read 0 and `irq` is low.
- R2: Register addresses are laid out as follows. Addresses 0..2 hold the polarity of ports 0..2. Addresses 3..5 hold the enables of ports 0..2. Addresses 6..8 hold the identification (pending) bits of ports 0..2. Bit i of port p belongs to `line_in[8*p+i]`. Polarity and enable registers read back what was written. Any other address reads 0, and writes to it change nothing.
- R3: With polarity bit 0 and enable bit 1, a 0-to-1 change on a line sets its pending bit. The bit becomes visible on the third rising clock edge after the input change.
- R4: With polarity bit 1 and enable bit 1, a 1-to-0 change sets the pending bit. The opposite edge sets nothing.
- R5: A line whose enable bit is 0 never sets its pending bit.
- R6: An input pulse one clock period wide is captured, and the pending bit then stays set with no further input activity.
- R7: Writing the identification register clears each pending bit written with 1 and leaves bits written with 0 unchanged.
- R8: When a new event on a line and a clear of that same line fall in the same cycle, the pending bit ends up set.
- R9: `irq` is high exactly while any pending bit of any port is set. It goes low in the cycle right after the write that clears the last pending bit.
- R10: Writing the polarity or enable registers while a line is steady does not set that line's pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 24 | Monitored lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt level, OR of all pending bits |

## Verification
The edge detector is driven with single rising steps, falling steps under both polarity settings, a four-line simultaneous step and a one-cycle pulse. Together these separate a correct edge-and-polarity qualifier from one that reacts to levels, ignores polarity, or misses short pulses.

Steady lines are held while their polarity and enable settings are rewritten. This separates true edge detection from a design that compares against configuration changes.

A clear write is timed to land in the same cycle that an event is detected on the same line. Partial clears with zero bits are also applied. These show the precedence between clear and capture, and that the clear acts bit by bit.

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int PORTS = 3,
  parameter int PW    = 8,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PORTS*PW-1:0] line_in,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [PW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [PW-1:0]       rd_data,
  output logic                irq
);
  localparam int N        = PORTS * PW;
  localparam int POL_BASE = 0;
  localparam int ENA_BASE = PORTS;
  localparam int PND_BASE = 2 * PORTS;

  logic [N-1:0] sync_a, sync_b, sync_c;
  logic [N-1:0] pol_q, ena_q, pend_q;
  logic [N-1:0] evt, clr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
    end else begin
      sync_a <= line_in;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  assign evt = ena_q & ((sync_b & ~sync_c & ~pol_q) | (~sync_b & sync_c & pol_q));

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pol_q[p*PW +: PW] <= '0;
        ena_q[p*PW +: PW] <= '0;
      end else if (wr_en) begin
        if (wr_addr == AW'(POL_BASE + p)) pol_q[p*PW +: PW] <= wr_data;
        if (wr_addr == AW'(ENA_BASE + p)) ena_q[p*PW +: PW] <= wr_data;
      end
    end
    assign clr_mask[p*PW +: PW] = (wr_en && wr_addr == AW'(PND_BASE + p)) ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | evt;
  end

  assign irq = |pend_q;

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (rd_addr == AW'(POL_BASE + p)) rd_data = pol_q[p*PW +: PW];
      if (rd_addr == AW'(ENA_BASE + p)) rd_data = ena_q[p*PW +: PW];
      if (rd_addr == AW'(PND_BASE + p)) rd_data = pend_q[p*PW +: PW];
    end
  end
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int N = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic [N-1:0] pend,
  input logic [N-1:0] evt,
  input logic [N-1:0] clr,
  input logic [N-1:0] s_new,
  input logic [N-1:0] s_old,
  input logic [N-1:0] ena
);
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0)); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~pend) == '0)); // R8
  AST_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~($past(s_new) ^ $past(s_old))) == '0)); // R10
  AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(ena)) == '0)); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && evt == '0) |=> !irq); // R9
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr == '0) |=> irq); // R9
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.N(PORTS*PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pend(pend_q), .evt(evt),
  .clr(clr_mask), .s_new(sync_b), .s_old(sync_c), .ena(ena_q)
);

// File: tb/cos_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cos_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] line_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq;

  always #4 clk = ~clk;

  cos_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  typedef struct {
    logic [3:0] addr;
    logic [7:0] data;
    logic       irq;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic expect_rd(input logic [3:0] a, input logic [7:0] d, input logic i, input string tag);
    item_t it;
    it.addr = a; it.data = d; it.irq = i; it.tag = tag;
    rd_addr = a;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        total++;
        if (rd_data !== e.data || irq !== e.irq) begin
          bad++;
          $display("FAIL %s addr=%0d actual data=%02h irq=%0b expected data=%02h irq=%0b",
                   e.tag, e.addr, rd_data, irq, e.data, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    expect_rd(4'd6, 8'h00, 1'b0, "R1");
    expect_rd(4'd0, 8'h00, 1'b0, "R1");
    expect_rd(4'd3, 8'h00, 1'b0, "R1");
    // R2 register map and readback
    wr(4'd0, 8'h02);
    wr(4'd3, 8'hFF);
    wr(4'd12, 8'hFF);
    expect_rd(4'd0, 8'h02, 1'b0, "R2");
    expect_rd(4'd3, 8'hFF, 1'b0, "R2");
    expect_rd(4'd12, 8'h00, 1'b0, "R2");
    expect_rd(4'd9, 8'h00, 1'b0, "R2");
    // R3 rising edge, line 0
    line_in[0] = 1'b1;
    settle();
    expect_rd(4'd6, 8'h01, 1'b1, "R3");
    // R4 falling polarity on line 1
    line_in[1] = 1'b1;
    settle();
    expect_rd(4'd6, 8'h01, 1'b1, "R4");
    line_in[1] = 1'b0;
    settle();
    expect_rd(4'd6, 8'h03, 1'b1, "R4");
    // R7 partial clear, R9 drop in next cycle
    wr(4'd6, 8'h01);
    expect_rd(4'd6, 8'h02, 1'b1, "R7");
    wr(4'd6, 8'h02);
    expect_rd(4'd6, 8'h00, 1'b0, "R9");
    // R5 disabled line
    line_in[8] = 1'b1;
    settle();
    expect_rd(4'd7, 8'h00, 1'b0, "R5");
    line_in[8] = 1'b0;
    settle();
    expect_rd(4'd7, 8'h00, 1'b0, "R5");
    // R10 settings changes on a steady high line
    line_in[9] = 1'b1;
    settle();
    wr(4'd4, 8'h02);
    settle();
    expect_rd(4'd7, 8'h00, 1'b0, "R10");
    wr(4'd1, 8'h02);
    settle();
    expect_rd(4'd7, 8'h00, 1'b0, "R10");
    line_in[9] = 1'b0;
    settle();
    expect_rd(4'd7, 8'h02, 1'b1, "R4");
    wr(4'd7, 8'h02);
    expect_rd(4'd7, 8'h00, 1'b0, "R9");
    // R3 several lines at once
    line_in[7:4] = 4'hF;
    settle();
    expect_rd(4'd6, 8'hF0, 1'b1, "R3");
    wr(4'd6, 8'hF0);
    expect_rd(4'd6, 8'h00, 1'b0, "R7");
    // R6 one-cycle pulse on line 16
    wr(4'd5, 8'hFF);
    line_in[16] = 1'b1;
    @(negedge clk);
    line_in[16] = 1'b0;
    settle();
    expect_rd(4'd8, 8'h01, 1'b1, "R6");
    repeat (10) @(negedge clk);
    expect_rd(4'd8, 8'h01, 1'b1, "R6");
    // R8 event and clear in the same cycle
    line_in[16] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(4'd8, 8'h01);
    expect_rd(4'd8, 8'h01, 1'b1, "R8");
    wr(4'd8, 8'h01);
    expect_rd(4'd8, 8'h00, 1'b0, "R7");
    // R7 writing zeros keeps bits
    line_in[3] = 1'b1;
    settle();
    wr(4'd6, 8'h00);
    expect_rd(4'd6, 8'h08, 1'b1, "R7");
    wr(4'd6, 8'h08);
    expect_rd(4'd6, 8'h00, 1'b0, "R9");
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule